// File: doc/BRIEF.md
# Stereo Automatic Level Control Engine

This block keeps a stereo audio stream below full scale by steering the gain code of an upstream programmable amplifier. The code steps the amplifier by 0.5 dB, and a higher code gives more gain. On every sample strobe the block looks at the signed left and right samples that leave the gain stage. When either channel is too loud, it cuts the code at once. After a run of quiet samples it raises the code again, step by step, but never above a reference code.

The new code can reach each channel's output as soon as it is computed. It can also be held per channel until that channel's sample changes sign, or until a timeout has passed. Gating on a sign change avoids audible clicks. Every setting is a static input, so no register interface sits inside the block. When the block is disabled, both outputs follow the reference code.

Top module: `stereo_alc`

## Requirements
- R1: While `alc_en` is 0, both gain outputs equal `ref_code` from the edge after it is sampled. The same holds from the first edge with `rst_n` low.
- R2: A strobe on which the larger channel magnitude strictly exceeds the limit level lowers the internal code by 1 (`lim_big_step`=0) or by 2 (`lim_big_step`=1). The limit level is 0x7892C2 when `lvl_sel`=0 and 0x65AC8C when `lvl_sel`=1. The magnitude is |sample| taken as an unsigned 24-bit value. A magnitude equal to the level does not trigger.
- R3: A limiter step never takes the code below 0x00, and the code never wraps around.
- R4: After `wait_len` consecutive quiet strobes, the code rises by 1 (`rec_big_step`=0) or by 2 (`rec_big_step`=1), and the quiet count restarts. A quiet strobe is one whose larger magnitude is at or below the window floor.
- R5: Recovery never takes the code above `ref_code`. A 2-step rise from one code below the reference stops at the reference.
- R6: A strobe whose larger magnitude lies above the window floor and at or below the limit level leaves the code unchanged and clears the quiet count. The floor is 0x5FC621 when `lvl_sel`=0 and 0x50C335 when `lvl_sel`=1.
- R7: With `fast_en`=1, if exactly one of the previous 8 strobes fired the limiter, the recovery wait is `wait_len`/4, with a minimum of 1.
- R8: With `zc_en`=0, both outputs carry the new code at the same edge that samples the strobe. The outputs change only on strobes.
- R9: With `zc_en`=1, each channel takes a pending code on a strobe where its sample's sign bit differs from its sign bit on the previous strobe, independently of the other channel.
- R10: With `zc_en`=1 and no sign change, a pending code is applied on the `wait_len`-th strobe after it became pending.
- R11: The right channel alone can trigger the limiter, in the same way as the left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe per stereo sample |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| alc_en | input | 1 | Enables level control; 0 holds outputs at reference |
| lim_big_step | input | 1 | Limiter cut: 0 = 1 code, 1 = 2 codes |
| rec_big_step | input | 1 | Recovery rise: 0 = 1 code, 1 = 2 codes |
| lvl_sel | input | 1 | Selects the higher (0) or lower (1) level pair |
| fast_en | input | 1 | Allows shortened recovery after an isolated peak |
| zc_en | input | 1 | Gates output updates on sign changes |
| ref_code | input | 8 | Reference and ceiling gain code |
| wait_len | input | 16 | Recovery wait and gating timeout, in strobes (0 acts as 1) |
| gain_left | output | 8 | Gain code for the left amplifier |
| gain_right | output | 8 | Gain code for the right amplifier |

## Verification
A corrupted quiet counter shows as a recovery step one or more strobes early or late. The bench checks the code after every strobe in long quiet runs, so the error appears within one recovery period. A wrong peak history gives a step after one quiet strobe where a full wait was expected, or the reverse, and this shows on the first strobe after the impulse. A stale per-channel sign or timeout register holds one output at the old code while the other moves. That mismatch is visible on the strobe where the crossing or the timeout should have applied.

// File: rtl/alc_pkg.sv
// Shared level constants for the stereo level controller.
// Assumes 24-bit magnitudes; wider data paths scale them by left shift.
package alc_pkg;
    localparam logic [23:0] LVL_LIMIT_HI  = 24'h7892C2; // limit level, lvl_sel=0
    localparam logic [23:0] LVL_LIMIT_LO  = 24'h65AC8C; // limit level, lvl_sel=1
    localparam logic [23:0] LVL_FLOOR_HI  = 24'h5FC621; // window floor, lvl_sel=0
    localparam logic [23:0] LVL_FLOOR_LO  = 24'h50C335; // window floor, lvl_sel=1
    localparam int          CHANNELS      = 2;
endpackage

// File: rtl/alc_level_detect.sv
// Magnitude classifier: takes |sample| on both channels, keeps the larger,
// and reports whether it is above the limit or inside the reset window.
// Assumes DATA_W >= 24; purely combinational.
module alc_level_detect #(
    parameter int DATA_W = 24
) (
    input  logic [DATA_W-1:0] smp_l,
    input  logic [DATA_W-1:0] smp_r,
    input  logic              lvl_sel,
    output logic              over,
    output logic              in_win
);
    import alc_pkg::*;
    localparam int SHIFT = DATA_W - 24;

    logic [DATA_W-1:0] mag [CHANNELS];
    logic [DATA_W-1:0] peak, lim_lvl, floor_lvl;

    // Absolute value per channel; the most negative input maps to 2^(W-1).
    for (genvar c = 0; c < CHANNELS; c++) begin : g_abs
        logic [DATA_W-1:0] s;
        assign s = (c == 0) ? smp_l : smp_r;
        assign mag[c] = s[DATA_W-1] ? (~s + 1'b1) : s;
    end

    // Threshold selection and comparison against the larger magnitude.
    always_comb begin
        peak      = (mag[0] > mag[1]) ? mag[0] : mag[1];
        lim_lvl   = DATA_W'(lvl_sel ? LVL_LIMIT_LO : LVL_LIMIT_HI) << SHIFT;
        floor_lvl = DATA_W'(lvl_sel ? LVL_FLOOR_LO : LVL_FLOOR_HI) << SHIFT;
        over      = peak > lim_lvl;
        in_win    = !over && (peak > floor_lvl);
    end
endmodule

// File: rtl/alc_gain_ctrl.sv
// Shared gain-code state machine: limiter cut, quiet-strobe counting,
// recovery toward the reference, and isolated-peak fast recovery.
// Assumes strobe is a single-cycle pulse; target_nxt is the registered
// code's next value and is used by the per-channel gates.
module alc_gain_ctrl #(
    parameter int GAIN_W   = 8,
    parameter int WAIT_W   = 16,
    parameter int HIST_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              strobe,
    input  logic              over,
    input  logic              in_win,
    input  logic              lim_big,
    input  logic              rec_big,
    input  logic              fast_en,
    input  logic [GAIN_W-1:0] ref_code,
    input  logic [WAIT_W-1:0] wait_len,
    output logic [GAIN_W-1:0] target_nxt
);
    logic [GAIN_W-1:0]   target;
    logic [WAIT_W-1:0]   cnt, cnt_nxt, per, base_per, fast_per;
    logic [HIST_LEN-1:0] hist, hist_nxt;
    logic [GAIN_W-1:0]   step_dn, step_up, dn_code, up_code;
    logic [GAIN_W:0]     up_wide;
    logic                fast_ok, wait_done;

    // Step sizes, saturating arithmetic and the active wait period.
    always_comb begin
        step_dn   = lim_big ? GAIN_W'(2) : GAIN_W'(1);
        step_up   = rec_big ? GAIN_W'(2) : GAIN_W'(1);
        dn_code   = (target > step_dn) ? target - step_dn : '0;
        up_wide   = {1'b0, target} + {1'b0, step_up};
        up_code   = (up_wide > {1'b0, ref_code}) ? ref_code : up_wide[GAIN_W-1:0];
        base_per  = (wait_len == '0) ? WAIT_W'(1) : wait_len;
        fast_per  = ((wait_len >> 2) == '0) ? WAIT_W'(1) : (wait_len >> 2);
        fast_ok   = fast_en && ($countones(hist) == 1);
        per       = fast_ok ? fast_per : base_per;
        wait_done = ((WAIT_W+1)'(cnt) + (WAIT_W+1)'(1)) >= (WAIT_W+1)'(per);
    end

    // Next-state decision for code, quiet counter and peak history.
    always_comb begin
        target_nxt = target;
        cnt_nxt    = cnt;
        hist_nxt   = hist;
        if (!enable) begin
            target_nxt = ref_code;
            cnt_nxt    = '0;
            hist_nxt   = '0;
        end else if (strobe) begin
            hist_nxt = {hist[HIST_LEN-2:0], over};
            if (over) begin
                target_nxt = dn_code;
                cnt_nxt    = '0;
            end else if (in_win) begin
                cnt_nxt    = '0;
            end else if (wait_done) begin
                cnt_nxt    = '0;
                if (target < ref_code) target_nxt = up_code;
            end else begin
                cnt_nxt    = cnt + WAIT_W'(1);
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= ref_code;
            cnt    <= '0;
            hist   <= '0;
        end else begin
            target <= target_nxt;
            cnt    <= cnt_nxt;
            hist   <= hist_nxt;
        end
    end
endmodule

// File: rtl/alc_zc_gate.sv
// Per-channel output stage: passes the shared code straight through, or
// holds it until the channel's sign flips or a timeout of strobes passes.
// Assumes period >= 1 and a single-cycle strobe.
module alc_zc_gate #(
    parameter int GAIN_W = 8,
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              strobe,
    input  logic              zc_en,
    input  logic              sign,
    input  logic [GAIN_W-1:0] target_nxt,
    input  logic [GAIN_W-1:0] ref_code,
    input  logic [WAIT_W-1:0] period,
    output logic [GAIN_W-1:0] gain
);
    logic              prev_sign;
    logic [WAIT_W-1:0] tmo, tmo_nxt;
    logic [GAIN_W-1:0] gain_nxt;
    logic              expired;

    // Choose between pass-through, crossing/timeout apply, or hold.
    always_comb begin
        gain_nxt = gain;
        tmo_nxt  = tmo;
        expired  = ((WAIT_W+1)'(tmo) + (WAIT_W+1)'(1)) >= (WAIT_W+1)'(period);
        if (!enable) begin
            gain_nxt = ref_code;
            tmo_nxt  = '0;
        end else if (!zc_en) begin
            gain_nxt = target_nxt;
            tmo_nxt  = '0;
        end else if (strobe) begin
            if (gain == target_nxt) begin
                tmo_nxt  = '0;
            end else if ((sign != prev_sign) || expired) begin
                gain_nxt = target_nxt;
                tmo_nxt  = '0;
            end else begin
                tmo_nxt  = tmo + WAIT_W'(1);
            end
        end
    end

    // Output code, timeout counter and last sign, synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain      <= ref_code;
            tmo       <= '0;
            prev_sign <= 1'b0;
        end else begin
            gain <= gain_nxt;
            tmo  <= tmo_nxt;
            if (strobe) prev_sign <= sign;
        end
    end
endmodule

// File: rtl/stereo_alc.sv
// Top level of the stereo level controller: one shared level detector and
// code controller, followed by one sign-change gate per channel.
// Assumes static configuration inputs and one-cycle sample strobes.
module stereo_alc #(
    parameter int DATA_W   = 24,
    parameter int GAIN_W   = 8,
    parameter int WAIT_W   = 16,
    parameter int HIST_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_left,
    input  logic [DATA_W-1:0] smp_right,
    input  logic              alc_en,
    input  logic              lim_big_step,
    input  logic              rec_big_step,
    input  logic              lvl_sel,
    input  logic              fast_en,
    input  logic              zc_en,
    input  logic [GAIN_W-1:0] ref_code,
    input  logic [WAIT_W-1:0] wait_len,
    output logic [GAIN_W-1:0] gain_left,
    output logic [GAIN_W-1:0] gain_right
);
    import alc_pkg::*;

    logic              over, in_win;
    logic [GAIN_W-1:0] target_nxt;
    logic [WAIT_W-1:0] tmo_period;
    logic [GAIN_W-1:0] gain_ch [CHANNELS];
    logic              sign_ch [CHANNELS];

    // Gating timeout uses the normal recovery period, never below one.
    assign tmo_period = (wait_len == '0) ? WAIT_W'(1) : wait_len;
    assign sign_ch[0] = smp_left[DATA_W-1];
    assign sign_ch[1] = smp_right[DATA_W-1];

    alc_level_detect #(.DATA_W(DATA_W)) u_detect (
        .smp_l   (smp_left),
        .smp_r   (smp_right),
        .lvl_sel (lvl_sel),
        .over    (over),
        .in_win  (in_win)
    );

    alc_gain_ctrl #(.GAIN_W(GAIN_W), .WAIT_W(WAIT_W), .HIST_LEN(HIST_LEN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (alc_en),
        .strobe     (smp_valid),
        .over       (over),
        .in_win     (in_win),
        .lim_big    (lim_big_step),
        .rec_big    (rec_big_step),
        .fast_en    (fast_en),
        .ref_code   (ref_code),
        .wait_len   (wait_len),
        .target_nxt (target_nxt)
    );

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        alc_zc_gate #(.GAIN_W(GAIN_W), .WAIT_W(WAIT_W)) u_gate (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (alc_en),
            .strobe     (smp_valid),
            .zc_en      (zc_en),
            .sign       (sign_ch[c]),
            .target_nxt (target_nxt),
            .ref_code   (ref_code),
            .period     (tmo_period),
            .gain       (gain_ch[c])
        );
    end

    assign gain_left  = gain_ch[0];
    assign gain_right = gain_ch[1];
endmodule

// File: rtl/stereo_alc_checker.sv
// Port-level temporal checks for stereo_alc, attached by bind.
module stereo_alc_checker #(
    parameter int GAIN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic              alc_en,
    input logic              zc_en,
    input logic [GAIN_W-1:0] ref_code,
    input logic [GAIN_W-1:0] gain_left,
    input logic [GAIN_W-1:0] gain_right
);
    AST_DISABLED_FOLLOWS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        !alc_en |=> (gain_left == $past(ref_code)) && (gain_right == $past(ref_code))); // R1

    AST_RISE_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_en && $stable(ref_code) && (gain_left > $past(gain_left))) |-> (gain_left <= ref_code)); // R5

    AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_en && !zc_en && $stable(alc_en) && $stable(zc_en) && $stable(ref_code))
        |=> ((int'(gain_left) <= int'($past(gain_left)) + 2) &&
             (int'(gain_left) + 2 >= int'($past(gain_left))))); // R2

    AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_en && !smp_valid && $stable(alc_en) && $stable(zc_en) && $stable(ref_code))
        |=> ($stable(gain_left) && $stable(gain_right))); // R8

    AST_CHANNELS_MATCH_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!zc_en && $past(!zc_en)) |-> (gain_left == gain_right)); // R8
endmodule

bind stereo_alc stereo_alc_checker #(.GAIN_W(GAIN_W)) u_stereo_alc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .alc_en     (alc_en),
    .zc_en      (zc_en),
    .ref_code   (ref_code),
    .gain_left  (gain_left),
    .gain_right (gain_right)
);

// File: tb/stereo_alc_bench.sv
`timescale 1ns/1ps
module stereo_alc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_left = '0, smp_right = '0;
    logic        alc_en = 1'b0, lim_big_step = 1'b0, rec_big_step = 1'b0;
    logic        lvl_sel = 1'b0, fast_en = 1'b0, zc_en = 1'b0;
    logic [7:0]  ref_code = 8'h60;
    logic [15:0] wait_len = 16'd4;
    logic [7:0]  gain_left, gain_right;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stereo_alc u_stereo_alc (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right),
        .alc_en(alc_en), .lim_big_step(lim_big_step), .rec_big_step(rec_big_step),
        .lvl_sel(lvl_sel), .fast_en(fast_en), .zc_en(zc_en),
        .ref_code(ref_code), .wait_len(wait_len),
        .gain_left(gain_left), .gain_right(gain_right)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One strobe; returns after the capturing edge, at a falling edge.
    task automatic strobe(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk);
        smp_left = l; smp_right = r; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Disabled strobe with zero samples: code to reference, signs positive.
    task automatic restart();
        @(negedge clk);
        alc_en = 1'b0;
        strobe(24'h0, 24'h0);
        alc_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset and disabled state.
        check("R1 reset left", gain_left, 8'h60);
        check("R1 reset right", gain_right, 8'h60);
        rst_n = 1'b1;
        ref_code = 8'h33;
        repeat (2) @(negedge clk);
        check("R1 disabled follows ref", gain_left, 8'h33);
        strobe(24'h7FFFFF, 24'h7FFFFF);
        check("R1 disabled ignores loud", gain_right, 8'h33);
        ref_code = 8'h60;

        // R2 / R11: sweep around the limit level, both signs, both channels.
        for (int ls = 0; ls < 2; ls++)
            for (int th = 0; th < 2; th++)
                for (int d = -1; d <= 1; d++)
                    for (int ng = 0; ng < 2; ng++)
                        for (int ch = 0; ch < 2; ch++) begin
                            int mag;
                            int s;
                            int exp;
                            mag = (th ? 32'h65AC8C : 32'h7892C2) + d;
                            s = ng ? -mag : mag;
                            lim_big_step = ls[0];
                            lvl_sel = th[0];
                            restart();
                            if (ch == 0) strobe(24'(s), 24'h0);
                            else         strobe(24'h0, 24'(s));
                            exp = (mag > (th ? 32'h65AC8C : 32'h7892C2)) ? 8'h60 - (ls ? 2 : 1) : 8'h60;
                            check(ch == 0 ? "R2 limiter left" : "R11 limiter right", gain_left, exp);
                            check("R8 ungated right equals", gain_right, exp);
                        end

        // R4 / R5: recovery after a cut, for both step sizes.
        lvl_sel = 1'b0; lim_big_step = 1'b1;
        for (int rb = 0; rb < 2; rb++) begin
            int exp;
            rec_big_step = rb[0];
            restart();
            strobe(24'h7F0000, 24'h0);
            strobe(24'h7F0000, 24'h0);
            exp = 8'h5C;
            check("R2 two cuts", gain_left, exp);
            for (int k = 1; k <= 16; k++) begin
                strobe(24'h0, 24'h000100);
                if (k % 4 == 0) exp = (exp + (rb ? 2 : 1) > 8'h60) ? 8'h60 : exp + (rb ? 2 : 1);
                check(exp == 8'h60 ? "R5 capped at ref" : "R4 recovery step", gain_left, exp);
            end
        end

        // R5: 2-step rise from one below the reference stops at it.
        rec_big_step = 1'b1; lim_big_step = 1'b0;
        restart();
        strobe(24'h7F0000, 24'h0);
        repeat (4) strobe(24'h0, 24'h0);
        check("R5 odd gap capped", gain_left, 8'h60);

        // R6: window strobe clears the quiet count (both level pairs).
        rec_big_step = 1'b0; lim_big_step = 1'b1;
        for (int th = 0; th < 2; th++) begin
            lvl_sel = th[0];
            restart();
            strobe(24'h7F0000, 24'h0);
            repeat (3) strobe(24'h0, 24'h0);
            strobe(th ? 24'h600000 : 24'h700000, 24'h0);
            check("R6 window no change", gain_left, 8'h5E);
            repeat (3) strobe(24'h0, 24'h0);
            check("R6 wait restarted", gain_left, 8'h5E);
            strobe(24'h0, 24'h0);
            check("R6 step after full wait", gain_left, 8'h5F);
        end
        lvl_sel = 1'b0;

        // R7: isolated peak shortens the wait to wait_len/4.
        for (int fe = 0; fe < 2; fe++) begin
            fast_en = fe[0];
            restart();
            strobe(24'h7F0000, 24'h0);
            strobe(24'h0, 24'h0);
            check("R7 fast recovery", gain_left, fe ? 8'h5F : 8'h5E);
        end
        fast_en = 1'b0;

        // R3: saturation at zero.
        ref_code = 8'h01;
        restart();
        strobe(24'h7F0000, 24'h0);
        check("R3 floor at zero", gain_left, 8'h00);
        strobe(24'h7F0000, 24'h0);
        check("R3 no wrap", gain_left, 8'h00);
        ref_code = 8'h60;

        // R9: per-channel sign-change gating.
        zc_en = 1'b1; lim_big_step = 1'b0;
        restart();
        strobe(24'h7F0000, 24'h000100);
        check("R9 held left", gain_left, 8'h60);
        check("R9 held right", gain_right, 8'h60);
        strobe(24'hFFFF00, 24'h000100);
        check("R9 left crossed", gain_left, 8'h5F);
        check("R9 right still held", gain_right, 8'h60);
        strobe(24'hFFFF00, 24'hFFFF00);
        check("R9 right crossed", gain_right, 8'h5F);

        // R10: timeout without a sign change.
        restart();
        strobe(24'h7F0000, 24'h000100);
        strobe(24'h000100, 24'h000100);
        strobe(24'h000100, 24'h000100);
        check("R10 before timeout", gain_left, 8'h60);
        strobe(24'h000100, 24'h000100);
        check("R10 timeout left", gain_left, 8'h5F);
        check("R10 timeout right", gain_right, 8'h5F);
        zc_en = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule